// File: doc/BRIEF.md
# Random Multi-Frequency Triangle Carrier Selector

This block produces a triangle carrier whose frequency is re-chosen at random at the start of every carrier period. It is meant to feed a PWM comparator stage that spreads switching harmonics. Four triangle generators run side by side at 1, 2, 3 and 4 kHz. They share one amplitude and differ only in how far each one steps per prescaler tick. Two maximal-length LFSRs, one 16 bits long and one 8 bits long, each contribute one bit, and together the two bits pick the generator that drives the output.

The choice changes only when the running carrier returns to its valley. At that moment both LFSRs advance once and all four generators restart from zero. The output therefore never jumps. A one-cycle strobe marks the first sample of each new period, and a 2-bit code reports which frequency is active. The `enable` input gates the prescaler, so the block can be frozen.

With the default parameters (`TICK_DIV` = 2604 and `PEAK_MUL` = 4) and a 250 MHz clock, the slowest carrier lasts 249,984 cycles, which is about 1 kHz.

Top module: `rand_multicarrier`

## Requirements
- R1: While reset is held, and afterwards until the first enabled tick, `carrier` reads 0 and `periodStart` reads 0. The LFSRs hold seeds 16'hACE1 and 8'h5A, so `freqCode` reads 3.
- R2: `freqCode` holds the active frequency in kHz minus one (0 = 1 kHz … 3 = 4 kHz). A period with code c lasts 24·PEAK_MUL·TICK_DIV/(c+1) clock cycles.
- R3: Within a period, `carrier` starts at 0 and rises by k = `freqCode`+1 per tick up to PEAK = 12·PEAK_MUL. It then falls by k per tick and never exceeds PEAK.
- R4: The MSBs of the two LFSRs select the frequency as follows: (16-bit MSB, 8-bit MSB) = (0,0) gives 2 kHz, (0,1) gives 3 kHz, (1,0) gives 4 kHz and (1,1) gives 1 kHz.
- R5: Each LFSR shifts toward its MSB and takes a new LSB. For the 16-bit register the new LSB is the XOR of bits 16, 14, 13 and 11, counting from 1 at the LSB. For the 8-bit register it is the XOR of bits 8, 6, 5 and 4. The state never becomes zero.
- R6: Both LFSRs advance exactly once per carrier period, at its end. `freqCode` stays constant for the whole period.
- R7: `periodStart` is high for exactly one cycle: the cycle in which the new period's first sample (0) and new code appear. It does not pulse for the first period after reset.
- R8: Every period boundary lands on the valley. The last sample of a period equals its step k, and the next sample is 0.
- R9: While `enable` is low, `carrier` and `freqCode` hold their values, `periodStart` stays low, and no tick or LFSR advance occurs.
- R10: The 8-bit bit stream seen across successive periods repeats with a period of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gates the tick prescaler; low freezes the block |
| carrier | output | VAL_W | Selected triangle carrier value, 0..PEAK |
| freqCode | output | 2 | Active frequency minus one, in kHz |
| periodStart | output | 1 | One-cycle pulse at the first sample of each new period |

## Verification
The end of a carrier period and a drop of `enable` can meet in the same cycle. The period end restarts the generators and advances both LFSRs; a low `enable` must suppress all of that. The bench provokes this by lowering `enable` in the cycle where the selected carrier sits one step above its valley, then holding it low for several cycles. The outcome is judged on three points. The carrier must stay at k, with no strobe and no change of code. After `enable` returns, the very next sample must be 0 with a single strobe. The new code must match a reference LFSR that has been advanced exactly once.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic tick;     // one prescaled step of every generator
    logic restart;  // period boundary: all generators back to the valley
  } ctrl_strobe_t;

  localparam int NUM_CARRIERS = 4;

  // Map of the two LFSR bits onto the frequency code (kHz minus one):
  // 00 -> 1 (2 kHz), 01 -> 2 (3 kHz), 10 -> 3 (4 kHz), 11 -> 0 (1 kHz).
  function automatic logic [1:0] pickCode(input logic bitLong, input logic bitShort);
    return {bitLong, bitShort} + 2'd1;
  endfunction

endpackage

// File: rtl/rmc_lfsr.sv
module rmc_lfsr #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rstN,
  input  logic advance,
  output logic outBit
);

  logic [WIDTH-1:0] state;
  logic feedback;

  assign feedback = ^(state & TAP_MASK);
  assign outBit   = state[WIDTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEED;
    else if (advance) state <= {state[WIDTH-2:0], feedback};
  end

  // R5: a maximal-length register never falls into the all-zero lockup
  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/rmc_trigen.sv
module rmc_trigen #(
  parameter int VAL_W = 6,
  parameter int PEAK  = 48,
  parameter int STEP  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic restart,
  output logic [VAL_W-1:0] val,
  output logic atValley
);

  localparam logic [VAL_W:0] PEAK_X = (VAL_W+1)'(PEAK);
  localparam logic [VAL_W:0] STEP_X = (VAL_W+1)'(STEP);
  localparam logic [VAL_W-1:0] STEP_V = VAL_W'(STEP);
  localparam logic [VAL_W-1:0] PEAK_V = VAL_W'(PEAK);

  logic falling;
  logic [VAL_W:0] sumUp;

  assign sumUp    = {1'b0, val} + STEP_X;
  // one step above zero on the way down: the next tick ends the period
  assign atValley = falling && (val == STEP_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      val     <= '0;
      falling <= 1'b0;
    end else if (restart) begin
      val     <= '0;
      falling <= 1'b0;
    end else if (tick) begin
      if (!falling) begin
        if (sumUp >= PEAK_X) begin
          val     <= PEAK_V;
          falling <= 1'b1;
        end else begin
          val <= sumUp[VAL_W-1:0];
        end
      end else if (val <= STEP_V) begin
        val     <= '0;
        falling <= 1'b0;
      end else begin
        val <= val - STEP_V;
      end
    end
  end

  p_peak_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    val <= PEAK_V);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !restart) |=> $stable(val));

endmodule

// File: rtl/rmc_datapath.sv
module rmc_datapath
  import rmc_pkg::*;
#(
  parameter int VAL_W = 6,
  parameter int PEAK  = 48
) (
  input  logic clk,
  input  logic rstN,
  input  ctrl_strobe_t strobes,
  input  logic [1:0] selCode,
  output logic [VAL_W-1:0] carrier,
  output logic selAtValley
);

  logic [VAL_W-1:0] genVal [NUM_CARRIERS];
  logic genValley [NUM_CARRIERS];

  for (genvar g = 0; g < NUM_CARRIERS; g++) begin : g_carrier
    rmc_trigen #(
      .VAL_W(VAL_W),
      .PEAK (PEAK),
      .STEP (g + 1)
    ) u_gen (
      .clk     (clk),
      .rstN    (rstN),
      .tick    (strobes.tick),
      .restart (strobes.restart),
      .val     (genVal[g]),
      .atValley(genValley[g])
    );
  end

  assign carrier     = genVal[selCode];
  assign selAtValley = genValley[selCode];

  // R8: every period boundary lands the output on the valley
  p_valley_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> carrier == '0);

endmodule

// File: rtl/rmc_control.sv
module rmc_control
  import rmc_pkg::*;
#(
  parameter int TICK_DIV = 2604
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic selAtValley,
  output ctrl_strobe_t strobes,
  output logic [1:0] selCode,
  output logic periodStart
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic longBit, shortBit;

  assign strobes.tick    = enable && (divCnt == CNT_LAST);
  assign strobes.restart = strobes.tick && selAtValley;
  assign selCode         = pickCode(longBit, shortBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             divCnt <= '0;
    else if (strobes.tick) divCnt <= '0;
    else if (enable)       divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) periodStart <= 1'b0;
    else       periodStart <= strobes.restart;
  end

  rmc_lfsr #(
    .WIDTH   (16),
    .TAP_MASK(16'hB400),
    .SEED    (16'hACE1)
  ) u_lfsrLong (
    .clk    (clk),
    .rstN   (rstN),
    .advance(strobes.restart),
    .outBit (longBit)
  );

  rmc_lfsr #(
    .WIDTH   (8),
    .TAP_MASK(8'hB8),
    .SEED    (8'h5A)
  ) u_lfsrShort (
    .clk    (clk),
    .rstN   (rstN),
    .advance(strobes.restart),
    .outBit (shortBit)
  );

  p_code_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.restart |=> $stable(selCode));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !periodStart);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!periodStart && $stable(selCode)));

endmodule

// File: rtl/rand_multicarrier.sv
module rand_multicarrier
  import rmc_pkg::*;
#(
  parameter int PEAK_MUL = 4,
  parameter int TICK_DIV = 2604,
  localparam int PEAK  = 12 * PEAK_MUL,
  localparam int VAL_W = $clog2(PEAK + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic [VAL_W-1:0] carrier,
  output logic [1:0] freqCode,
  output logic periodStart
);

  ctrl_strobe_t strobes;
  logic selAtValley;

  rmc_control #(
    .TICK_DIV(TICK_DIV)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .selAtValley(selAtValley),
    .strobes    (strobes),
    .selCode    (freqCode),
    .periodStart(periodStart)
  );

  rmc_datapath #(
    .VAL_W(VAL_W),
    .PEAK (PEAK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .selCode    (freqCode),
    .carrier    (carrier),
    .selAtValley(selAtValley)
  );

endmodule

// File: tb/sim_rand_multicarrier.sv
`timescale 1ns/1ps
module sim_rand_multicarrier;

  localparam int PEAK_MUL = 1;
  localparam int TICK_DIV = 1;
  localparam int PEAK     = 12 * PEAK_MUL;
  localparam int VAL_W    = $clog2(PEAK + 1);
  localparam int NPER     = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [VAL_W-1:0] carrier;
  logic [1:0] freqCode;
  logic periodStart;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [15:0] m16;
  logic [7:0]  m8;
  bit obs8 [NPER];

  always #2 clk = ~clk;

  rand_multicarrier #(.PEAK_MUL(PEAK_MUL), .TICK_DIV(TICK_DIV)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .carrier(carrier), .freqCode(freqCode), .periodStart(periodStart)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5 reference register update
  function automatic logic [15:0] next16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic logic [7:0] next8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
  // R4 mapping, code = kHz - 1
  function automatic int expCode();
    case ({m16[15], m8[7]})
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 3;
      default: return 0;
    endcase
  endfunction
  function automatic int triVal(input int j, input int k);
    int v;
    v = j * k;
    return (v > PEAK) ? (2 * PEAK - v) : v;
  endfunction
  function automatic void advModel();
    m16 = next16(m16);
    m8  = next8(m8);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  // R1: reset values, held while enable is low
  task automatic test_reset();
    rstN = 1'b0; enable = 1'b0;
    m16 = 16'hACE1; m8 = 8'h5A;
    repeat (3) step();
    check(carrier == 0, "R1 carrier in reset", int'(carrier), 0);
    check(freqCode == 2'd3, "R1 code in reset", int'(freqCode), 3);
    rstN = 1'b1;
    repeat (3) step();
    check(carrier == 0 && periodStart == 1'b0, "R1 idle after reset", int'(carrier), 0);
    check(freqCode == 2'd3, "R1 seed code", int'(freqCode), 3);
    enable = 1'b1;   // next posedge is j=1 of period 1
  endtask

  // R9 + R8 + R7: freeze mid-period and exactly on the boundary cycle
  task automatic test_enable();
    int k;
    int len;
    bit ok;
    k = expCode() + 1;                  // period 1: 4 kHz, 6 ticks
    step(); step();                     // j = 2
    check(carrier == triVal(2, k), "R3 rise", int'(carrier), triVal(2, k));
    enable = 1'b0;
    ok = 1'b1;
    repeat (10) begin
      step();
      if (carrier != triVal(2, k) || periodStart || freqCode != 2'(k - 1)) ok = 1'b0;
    end
    check(ok, "R9 frozen mid-period", int'(carrier), triVal(2, k));
    enable = 1'b1;
    for (int j = 3; j < 24 / k; j++) step();
    check(carrier == k, "R8 last sample equals step", int'(carrier), k);
    step();
    advModel();
    check(carrier == 0, "R8 valley at boundary", int'(carrier), 0);
    check(periodStart == 1'b1, "R7 strobe at first period", int'(periodStart), 1);
    check(int'(freqCode) == expCode(), "R4 second code", int'(freqCode), expCode());
    // period 2: stop in the cycle whose next tick would end the period
    k = expCode() + 1;
    len = 24 / k;
    for (int j = 1; j < len; j++) step();
    check(carrier == k, "R8 pre-valley", int'(carrier), k);
    enable = 1'b0;
    ok = 1'b1;
    repeat (8) begin
      step();
      if (carrier != k || periodStart || freqCode != 2'(k - 1)) ok = 1'b0;
    end
    check(ok, "R9 frozen on boundary cycle", int'(carrier), k);
    enable = 1'b1;
    step();
    advModel();
    check(carrier == 0 && periodStart, "R7 resume strobe", int'(carrier), 0);
    check(int'(freqCode) == expCode(), "R6 single advance across freeze",
          int'(freqCode), expCode());
  endtask

  // one full period starting at the current sample j=0
  task automatic run_period(input int idx);
    int k;
    int len;
    int code;
    bit shapeOk;
    bit codeOk;
    bit strobeOk;
    code = expCode();
    k = code + 1;
    len = 24 * PEAK_MUL / k;
    obs8[idx] = 1'(2'(freqCode - 2'd1));
    codeOk   = (int'(freqCode) == code);
    shapeOk  = (carrier == 0);
    strobeOk = (periodStart == 1'b1);
    for (int j = 1; j < len; j++) begin
      step();
      if (int'(carrier) != triVal(j, k)) shapeOk = 1'b0;
      if (int'(freqCode) != code) codeOk = 1'b0;
      if (periodStart) strobeOk = 1'b0;
    end
    step();
    advModel();
    if (carrier != 0 || !periodStart) shapeOk = 1'b0;
    check(shapeOk, "R3 R8 R2 triangle shape and length", int'(carrier), 0);
    check(codeOk, "R4 R6 code held and mapped", int'(freqCode), code);
    check(strobeOk, "R7 single strobe per period", int'(periodStart), 1);
  endtask

  task automatic test_sequence();
    bit rep;
    bit shortOk;
    for (int i = 0; i < NPER; i++) run_period(i);
    rep = 1'b1;
    for (int i = 0; i + 255 < NPER; i++) if (obs8[i] != obs8[i + 255]) rep = 1'b0;
    check(rep, "R10 8-bit stream repeats after 255", 0, 1);
    shortOk = 1'b0;
    for (int i = 0; i < 40; i++) if (obs8[i] != obs8[i + 127]) shortOk = 1'b1;
    check(shortOk, "R5 R10 no shorter repeat at 127", 0, 1);
  endtask

  initial begin
    test_reset();
    test_enable();
    test_sequence();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule